// File: doc/BRIEF.md
# Short-Vector Exception Capture Unit

This block steps a floating-point instruction that works on a short vector of registers through its iterations, one per cycle. It sends each iteration's register addresses to the arithmetic pipeline. It then tracks the per-iteration status that the pipeline returns, in order. When no iteration reports a problem, the instruction retires and decode moves on.

When an iteration reports a potential exception, the unit enters an exceptional state and stops issuing iterations. It stores the following:
- the cause flags;
- an encoded count of the iterations not yet completed;
- a copy of the instruction whose register fields are rewritten to the addresses of the failing iteration;
- the contents and valid flag of a second pending instruction slot.

The next instruction waits in decode and is not accepted. After a handler has run, that instruction can be reissued. A clear pulse releases the captured state.

Register addresses are 5 bits wide. The top two bits select a bank of eight registers and the low three bits select the register inside that bank. Each iteration moves the low bits forward by the stride, wrapping inside the bank.

Top module: `svx_capture_unit`

## Requirements
- R1: After reset, `exc_state_o`, `dec_stall_o`, `iter_valid_o`, `exc_cause_o`, `rem_iter_o`, `cap_word_o`, `slot2_valid_o` and `slot2_word_o` are all zero.
- R2: An instruction accepted at a clock edge (when `dec_valid_i` is high and `dec_stall_o` is low) issues `dec_len_i`+1 iterations. They come in consecutive cycles starting right after that edge, with `iter_idx_o` counting 0, 1, 2 and so on.
- R3: For iteration i, each address keeps bits [4:3] and sets bits [2:0] to (base[2:0] + step*i) mod 8. Stride code 2'b11 gives step 2; every other code gives step 1.
- R4: `dec_stall_o` is low while the unit is idle and high from the cycle after acceptance. It falls after the edge that takes a clean status for the last iteration. After a captured exception it stays high until the state is cleared.
- R5: A status with `res_valid_i` high and a nonzero `res_exc_i`, taken while an instruction is in flight, sets `exc_state_o` at that edge. `exc_cause_o` then equals that `res_exc_i` exactly.
- R6: `rem_iter_o` holds (len − k) − 1 for an exception at iteration k, and 0 when k equals len.
- R7: `cap_word_o` is {opcode[7:0], dst[4:0], srcn[4:0], srcm[4:0]}, with each address taken at the failing iteration. Each address reads as {1-bit extension, 4-bit field}.
- R8: A scalar instruction (length code 0) that faults gives `rem_iter_o` = 0 and addresses equal to the decoded ones.
- R9: At capture, `slot2_valid_o` takes `slot2_valid_i`. `slot2_word_o` takes `slot2_word_i` when that flag is 1, and 0 otherwise.
- R10: While `exc_state_o` is 1, `dec_valid_i` is not accepted and no iteration is issued. A `clear_i` pulse zeroes every captured output and lowers `dec_stall_o` on the next cycle.
- R11: Statuses that arrive while idle, or while in the exceptional state, change no output.
- R12: No iteration issues after the edge that captures an exception. The iterations already issued are those up to the cycle of the failing status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dec_valid_i | input | 1 | Instruction present in decode |
| dec_opc_i | input | OPC_W | Opcode bits carried into the captured copy |
| dec_dst_i | input | AW | Destination base address |
| dec_srcn_i | input | AW | First source base address |
| dec_srcm_i | input | AW | Second source base address |
| dec_len_i | input | LEN_W | Length code (iterations − 1) |
| dec_stride_i | input | 2 | Stride code |
| dec_stall_o | output | 1 | Holds the decode instruction |
| iter_valid_o | output | 1 | An iteration issues this cycle |
| iter_idx_o | output | LEN_W | Iteration number |
| iter_dst_o | output | AW | Iteration destination address |
| iter_srcn_o | output | AW | Iteration first source address |
| iter_srcm_o | output | AW | Iteration second source address |
| res_valid_i | input | 1 | In-order per-iteration status valid |
| res_exc_i | input | CW | Potential-exception flags of that status |
| slot2_valid_i | input | 1 | A second instruction is pending |
| slot2_word_i | input | W2 | Second pending instruction |
| clear_i | input | 1 | Releases the exceptional state |
| exc_state_o | output | 1 | Exceptional state |
| exc_cause_o | output | CW | Captured cause flags |
| rem_iter_o | output | LEN_W | Remaining iterations, minus-one encoded |
| cap_word_o | output | OPC_W+3*AW | Rewritten instruction copy |
| slot2_valid_o | output | 1 | Captured second-slot valid flag |
| slot2_word_o | output | W2 | Captured second-slot word |

## Verification
The bench targets these corner cases:
- **Fault on the first of four iterations.** A wrong remaining-count encoding shows up here as 3 or 1 instead of 2.
- **Fault on the final iteration.** An encoder without the zero floor would wrap to all ones.
- **Stride-two run across the bank edge.** A design that let the carry spill into the bank bits would produce addresses in the wrong bank.
- **Late-status faults.** Iterations keep issuing until the failing status lands. A unit that stopped too early or too late would issue too few or too many iterations for the scoreboard.
- **Idle and exceptional-state intrusions.** Stray statuses and new decode requests arrive during these states. A unit that took them would overwrite the cause or start a fresh sequence.

// File: rtl/svx_pkg.sv
package svx_pkg;

   typedef logic [1:0] stride_code_t;

   localparam stride_code_t STRIDE_CODE_TWO = 2'b11;

   // Step applied to the in-bank register index per iteration.
   function automatic logic [1:0] stride_step(input stride_code_t code);
      return (code == STRIDE_CODE_TWO) ? 2'd2 : 2'd1;
   endfunction

endpackage

// File: rtl/svx_addr_step.sv
module svx_addr_step
   import svx_pkg::*;
#(
   parameter int AW         = 5,
   parameter int BANK_LSB   = 3,
   parameter int LEN_W      = 3,
   parameter bit STRIDE2_EN = 1'b1
) (
   input  logic [AW-1:0]    base_i,
   input  stride_code_t     code_i,
   input  logic [LEN_W-1:0] idx_i,
   output logic [AW-1:0]    addr_o
);

   localparam int PW = LEN_W + 2;

   logic [1:0]          step;
   logic [PW-1:0]       prod;
   logic [BANK_LSB-1:0] low;

   generate
      if (STRIDE2_EN) begin : g_stride_sel
         assign step = stride_step(code_i);
      end else begin : g_stride_one
         logic unused_code;
         assign unused_code = ^code_i;
         assign step        = 2'd1;
      end
   endgenerate

   // Wrap inside the bank: only the low bits take the offset.
   assign prod   = PW'(step) * PW'(idx_i);
   assign low    = base_i[BANK_LSB-1:0] + BANK_LSB'(prod);
   assign addr_o = {base_i[AW-1:BANK_LSB], low};

endmodule

// File: rtl/svx_seq.sv
module svx_seq #(
   parameter int LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             res_valid_i,
   input  logic             res_exc_any_i,
   output logic             active_o,
   output logic             iter_valid_o,
   output logic [LEN_W-1:0] iter_idx_o,
   output logic [LEN_W-1:0] res_idx_o,
   output logic             hit_o
);

   logic             active_q;
   logic             iss_done_q;
   logic [LEN_W-1:0] iss_cnt_q;
   logic [LEN_W-1:0] res_cnt_q;

   assign iter_valid_o = active_q & ~iss_done_q;
   assign iter_idx_o   = iss_cnt_q;
   assign res_idx_o    = res_cnt_q;
   assign active_o     = active_q;
   assign hit_o        = active_q & res_valid_i & res_exc_any_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         iss_done_q <= 1'b0;
         iss_cnt_q  <= '0;
         res_cnt_q  <= '0;
      end else if (accept_i) begin
         active_q   <= 1'b1;
         iss_done_q <= 1'b0;
         iss_cnt_q  <= '0;
         res_cnt_q  <= '0;
      end else if (active_q) begin
         if (iter_valid_o) begin
            if (iss_cnt_q == len_i) iss_done_q <= 1'b1;
            else                    iss_cnt_q  <= iss_cnt_q + 1'b1;
         end
         if (res_valid_i) begin
            if (res_exc_any_i || (res_cnt_q == len_i)) active_q  <= 1'b0;
            else                                       res_cnt_q <= res_cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/svx_capture.sv
module svx_capture #(
   parameter int LEN_W = 3,
   parameter int AW    = 5,
   parameter int OPC_W = 8,
   parameter int CW    = 4,
   parameter int W2    = 32,
   localparam int WW   = OPC_W + 3*AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             clear_i,
   input  logic [CW-1:0]    cause_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [LEN_W-1:0] idx_i,
   input  logic [OPC_W-1:0] opc_i,
   input  logic [AW-1:0]    dst_i,
   input  logic [AW-1:0]    srcn_i,
   input  logic [AW-1:0]    srcm_i,
   input  logic             slot2_valid_i,
   input  logic [W2-1:0]    slot2_word_i,
   output logic             exc_state_o,
   output logic [CW-1:0]    cause_o,
   output logic [LEN_W-1:0] rem_o,
   output logic [WW-1:0]    word_o,
   output logic             slot2_valid_o,
   output logic [W2-1:0]    slot2_word_o
);

   logic [LEN_W-1:0] left;
   logic [LEN_W-1:0] rem_enc;

   // Iterations after the failing one, stored minus one, floored at zero.
   assign left    = len_i - idx_i;
   assign rem_enc = (left == '0) ? '0 : left - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_state_o   <= 1'b0;
         cause_o       <= '0;
         rem_o         <= '0;
         word_o        <= '0;
         slot2_valid_o <= 1'b0;
         slot2_word_o  <= '0;
      end else if (hit_i) begin
         exc_state_o   <= 1'b1;
         cause_o       <= cause_i;
         rem_o         <= rem_enc;
         word_o        <= {opc_i, dst_i, srcn_i, srcm_i};
         slot2_valid_o <= slot2_valid_i;
         slot2_word_o  <= slot2_valid_i ? slot2_word_i : '0;
      end else if (clear_i && exc_state_o) begin
         exc_state_o   <= 1'b0;
         cause_o       <= '0;
         rem_o         <= '0;
         word_o        <= '0;
         slot2_valid_o <= 1'b0;
         slot2_word_o  <= '0;
      end
   end

endmodule

// File: rtl/svx_capture_unit.sv
module svx_capture_unit
   import svx_pkg::*;
#(
   parameter int LEN_W      = 3,
   parameter int AW         = 5,
   parameter int BANK_LSB   = 3,
   parameter int OPC_W      = 8,
   parameter int CW         = 4,
   parameter int W2         = 32,
   parameter bit STRIDE2_EN = 1'b1,
   localparam int WW        = OPC_W + 3*AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid_i,
   input  logic [OPC_W-1:0] dec_opc_i,
   input  logic [AW-1:0]    dec_dst_i,
   input  logic [AW-1:0]    dec_srcn_i,
   input  logic [AW-1:0]    dec_srcm_i,
   input  logic [LEN_W-1:0] dec_len_i,
   input  logic [1:0]       dec_stride_i,
   output logic             dec_stall_o,
   output logic             iter_valid_o,
   output logic [LEN_W-1:0] iter_idx_o,
   output logic [AW-1:0]    iter_dst_o,
   output logic [AW-1:0]    iter_srcn_o,
   output logic [AW-1:0]    iter_srcm_o,
   input  logic             res_valid_i,
   input  logic [CW-1:0]    res_exc_i,
   input  logic             slot2_valid_i,
   input  logic [W2-1:0]    slot2_word_i,
   input  logic             clear_i,
   output logic             exc_state_o,
   output logic [CW-1:0]    exc_cause_o,
   output logic [LEN_W-1:0] rem_iter_o,
   output logic [WW-1:0]    cap_word_o,
   output logic             slot2_valid_o,
   output logic [W2-1:0]    slot2_word_o
);

   localparam int NFLD = 3;

   generate
      if (BANK_LSB < 1 || BANK_LSB >= AW) begin : g_bad_bank
         $error("BANK_LSB must lie inside the address width");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
      if (CW < 1 || OPC_W < 1 || W2 < 1) begin : g_bad_width
         $error("cause, opcode and slot widths must be positive");
      end
   endgenerate

   logic                active;
   logic                accept;
   logic                hit;
   logic [LEN_W-1:0]    res_idx;
   logic [OPC_W-1:0]    opc_q;
   logic [LEN_W-1:0]    len_q;
   stride_code_t        code_q;
   logic [AW-1:0]       dec_addr [NFLD];
   logic [AW-1:0]       base_q   [NFLD];
   logic [AW-1:0]       iter_addr[NFLD];
   logic [AW-1:0]       cap_addr [NFLD];

   assign dec_stall_o = active | exc_state_o;
   assign accept      = dec_valid_i & ~dec_stall_o;

   assign dec_addr[0] = dec_dst_i;
   assign dec_addr[1] = dec_srcn_i;
   assign dec_addr[2] = dec_srcm_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opc_q  <= '0;
         len_q  <= '0;
         code_q <= '0;
      end else if (accept) begin
         opc_q  <= dec_opc_i;
         len_q  <= dec_len_i;
         code_q <= dec_stride_i;
      end
   end

   for (genvar f = 0; f < NFLD; f++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      base_q[f] <= '0;
         else if (accept) base_q[f] <= dec_addr[f];
      end

      svx_addr_step #(
         .AW(AW), .BANK_LSB(BANK_LSB), .LEN_W(LEN_W), .STRIDE2_EN(STRIDE2_EN)
      ) u_iter_step (
         .base_i(base_q[f]), .code_i(code_q), .idx_i(iter_idx_o), .addr_o(iter_addr[f])
      );

      svx_addr_step #(
         .AW(AW), .BANK_LSB(BANK_LSB), .LEN_W(LEN_W), .STRIDE2_EN(STRIDE2_EN)
      ) u_cap_step (
         .base_i(base_q[f]), .code_i(code_q), .idx_i(res_idx), .addr_o(cap_addr[f])
      );
   end

   assign iter_dst_o  = iter_addr[0];
   assign iter_srcn_o = iter_addr[1];
   assign iter_srcm_o = iter_addr[2];

   svx_seq #(.LEN_W(LEN_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept_i     (accept),
      .len_i        (len_q),
      .res_valid_i  (res_valid_i),
      .res_exc_any_i(|res_exc_i),
      .active_o     (active),
      .iter_valid_o (iter_valid_o),
      .iter_idx_o   (iter_idx_o),
      .res_idx_o    (res_idx),
      .hit_o        (hit)
   );

   svx_capture #(
      .LEN_W(LEN_W), .AW(AW), .OPC_W(OPC_W), .CW(CW), .W2(W2)
   ) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit_i        (hit),
      .clear_i      (clear_i),
      .cause_i      (res_exc_i),
      .len_i        (len_q),
      .idx_i        (res_idx),
      .opc_i        (opc_q),
      .dst_i        (cap_addr[0]),
      .srcn_i       (cap_addr[1]),
      .srcm_i       (cap_addr[2]),
      .slot2_valid_i(slot2_valid_i),
      .slot2_word_i (slot2_word_i),
      .exc_state_o  (exc_state_o),
      .cause_o      (exc_cause_o),
      .rem_o        (rem_iter_o),
      .word_o       (cap_word_o),
      .slot2_valid_o(slot2_valid_o),
      .slot2_word_o (slot2_word_o)
   );

endmodule

// File: rtl/svx_capture_unit_chk.sv
module svx_capture_unit_chk #(
   parameter int LEN_W = 3,
   parameter int CW    = 4,
   parameter int WW    = 23
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dec_stall_o,
   input logic             iter_valid_o,
   input logic [LEN_W-1:0] iter_idx_o,
   input logic             res_valid_i,
   input logic [CW-1:0]    res_exc_i,
   input logic             clear_i,
   input logic             exc_state_o,
   input logic [CW-1:0]    exc_cause_o,
   input logic [LEN_W-1:0] rem_iter_o,
   input logic [WW-1:0]    cap_word_o
);

   AST_NO_ISSUE_IN_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      exc_state_o |-> !iter_valid_o); // R12

   AST_STALL_IN_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      exc_state_o |-> dec_stall_o); // R4

   AST_CAPTURE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_i && (res_exc_i != '0) && dec_stall_o && !exc_state_o)
      |=> (exc_state_o && (exc_cause_o == $past(res_exc_i)))); // R5

   AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_state_o && !clear_i)
      |=> ($stable(exc_cause_o) && $stable(cap_word_o) && $stable(rem_iter_o))); // R11

   AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_state_o && clear_i) |=> (!exc_state_o && (exc_cause_o == '0))); // R10

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (iter_valid_o && (iter_idx_o != '0))
      |-> ($past(iter_valid_o) && (iter_idx_o == LEN_W'($past(iter_idx_o) + 1'b1)))); // R2

endmodule

bind svx_capture_unit svx_capture_unit_chk #(
   .LEN_W(LEN_W), .CW(CW), .WW(WW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dec_stall_o (dec_stall_o),
   .iter_valid_o(iter_valid_o),
   .iter_idx_o  (iter_idx_o),
   .res_valid_i (res_valid_i),
   .res_exc_i   (res_exc_i),
   .clear_i     (clear_i),
   .exc_state_o (exc_state_o),
   .exc_cause_o (exc_cause_o),
   .rem_iter_o  (rem_iter_o),
   .cap_word_o  (cap_word_o)
);

// File: tb/svx_capture_unit_test.sv
module svx_capture_unit_test;

   localparam int LEN_W = 3;
   localparam int AW    = 5;
   localparam int OPC_W = 8;
   localparam int CW    = 4;
   localparam int W2    = 32;
   localparam int WW    = OPC_W + 3*AW;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             dec_valid_i = 1'b0;
   logic [OPC_W-1:0] dec_opc_i = '0;
   logic [AW-1:0]    dec_dst_i = '0, dec_srcn_i = '0, dec_srcm_i = '0;
   logic [LEN_W-1:0] dec_len_i = '0;
   logic [1:0]       dec_stride_i = '0;
   logic             dec_stall_o, iter_valid_o;
   logic [LEN_W-1:0] iter_idx_o;
   logic [AW-1:0]    iter_dst_o, iter_srcn_o, iter_srcm_o;
   logic             res_valid_i = 1'b0;
   logic [CW-1:0]    res_exc_i = '0;
   logic             slot2_valid_i = 1'b0;
   logic [W2-1:0]    slot2_word_i = '0;
   logic             clear_i = 1'b0;
   logic             exc_state_o;
   logic [CW-1:0]    exc_cause_o;
   logic [LEN_W-1:0] rem_iter_o;
   logic [WW-1:0]    cap_word_o;
   logic             slot2_valid_o;
   logic [W2-1:0]    slot2_word_o;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   svx_capture_unit uut (.*);

   typedef struct packed {
      logic [LEN_W-1:0] idx;
      logic [AW-1:0]    d, n, m;
   } it_t;

   it_t exp_q[$];
   it_t mon_e;

   function automatic logic [AW-1:0] step_addr(logic [AW-1:0] b, logic [1:0] st, int i);
      int s;
      int lo;
      s  = (st == 2'b11) ? 2 : 1;
      lo = (int'(b[2:0]) + s*i) % 8;
      return {b[4:3], 3'(lo)};
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor: every issued iteration must match the queue head.
   always @(negedge clk) begin
      if (rst_n && iter_valid_o) begin
         if (exp_q.size() == 0) begin
            total++;
            bad++;
            $display("FAIL R12 unexpected iteration actual=%0d expected=none", iter_idx_o);
         end else begin
            mon_e = exp_q.pop_front();
            chk("R2", "iteration index", 64'(iter_idx_o), 64'(mon_e.idx));
            chk("R3", "iteration addresses", 64'({iter_dst_o, iter_srcn_o, iter_srcm_o}),
                64'({mon_e.d, mon_e.n, mon_e.m}));
         end
      end
   end

   // Driver: issue one instruction, return statuses with latency lat,
   // fault at iteration k (k < 0 for a clean run), then check the capture.
   task automatic run_vec(logic [OPC_W-1:0] opc, logic [AW-1:0] d, logic [AW-1:0] n,
                          logic [AW-1:0] m, logic [LEN_W-1:0] len, logic [1:0] st,
                          int k, logic [CW-1:0] cause, int lat,
                          logic s2v, logic [W2-1:0] s2w);
      int last_iss;
      int stop;
      int left;
      int j;
      last_iss = (k < 0) ? int'(len) : (((k + lat) > int'(len)) ? int'(len) : k + lat);
      for (int i = 0; i <= last_iss; i++)
         exp_q.push_back({LEN_W'(i), step_addr(d, st, i), step_addr(n, st, i), step_addr(m, st, i)});
      @(negedge clk);
      chk("R4", "stall before accept", 64'(dec_stall_o), 64'(0));
      dec_valid_i = 1'b1; dec_opc_i = opc; dec_dst_i = d; dec_srcn_i = n; dec_srcm_i = m;
      dec_len_i = len; dec_stride_i = st; slot2_valid_i = s2v; slot2_word_i = s2w;
      @(negedge clk);
      dec_valid_i = 1'b0;
      chk("R4", "stall while sequencing", 64'(dec_stall_o), 64'(1));
      stop = (k < 0) ? int'(len) : k;
      for (int c = 0; c < 64; c++) begin
         j = c - lat;
         if (j >= 0 && j <= stop) begin
            res_valid_i = 1'b1;
            res_exc_i   = (j == k) ? cause : '0;
         end else begin
            res_valid_i = 1'b0;
            res_exc_i   = '0;
         end
         @(negedge clk);
         if (j >= stop) break;
      end
      res_valid_i = 1'b0;
      res_exc_i   = '0;
      chk("R12", "leftover expected iterations", 64'(exp_q.size()), 64'(0));
      exp_q.delete();
      if (k < 0) begin
         chk("R4", "stall after clean finish", 64'(dec_stall_o), 64'(0));
         chk("R5", "no exception on clean run", 64'(exc_state_o), 64'(0));
      end else begin
         left = int'(len) - k;
         chk("R5", "exceptional state", 64'(exc_state_o), 64'(1));
         chk("R5", "cause flags", 64'(exc_cause_o), 64'(cause));
         chk("R6", "remaining count", 64'(rem_iter_o), 64'((left == 0) ? 0 : left - 1));
         chk("R7", "captured word", 64'(cap_word_o),
             64'({opc, step_addr(d, st, k), step_addr(n, st, k), step_addr(m, st, k)}));
         chk("R9", "slot2 valid", 64'(slot2_valid_o), 64'(s2v));
         chk("R9", "slot2 word", 64'(slot2_word_o), 64'(s2v ? s2w : '0));
         chk("R4", "stall held in exception", 64'(dec_stall_o), 64'(1));
      end
      slot2_valid_i = 1'b0;
      slot2_word_i  = '0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      clear_i = 1'b1;
      @(negedge clk);
      clear_i = 1'b0;
      chk("R10", "state after clear", 64'(exc_state_o), 64'(0));
      chk("R10", "cause after clear", 64'(exc_cause_o), 64'(0));
      chk("R10", "word after clear", 64'(cap_word_o), 64'(0));
      chk("R10", "remaining after clear", 64'(rem_iter_o), 64'(0));
      chk("R10", "slot2 after clear", 64'(slot2_valid_o), 64'(0));
      chk("R10", "stall after clear", 64'(dec_stall_o), 64'(0));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "reset state", 64'({exc_state_o, dec_stall_o, iter_valid_o, exc_cause_o, rem_iter_o}), 64'(0));
      chk("R1", "reset word", 64'(cap_word_o), 64'(0));
      chk("R1", "reset slot2", 64'({slot2_valid_o, slot2_word_o}), 64'(0));
      rst_n = 1'b1;

      // Four-iteration double add faulting on its first iteration (overflow).
      run_vec(8'hA5, 5'd4, 5'd4, 5'd12, 3'd3, 2'b00, 0, 4'b0010, 2, 1'b0, 32'h1234_5678);
      chk("R7", "first-iteration copy", 64'(cap_word_o), 64'({8'hA5, 5'b00100, 5'b00100, 5'b01100}));
      chk("R6", "three left encodes as two", 64'(rem_iter_o), 64'(2));

      // R10/R11: decode requests and stray statuses while exceptional.
      @(negedge clk);
      dec_valid_i = 1'b1; dec_len_i = 3'd2; res_valid_i = 1'b1; res_exc_i = 4'b0100;
      repeat (3) @(negedge clk);
      dec_valid_i = 1'b0; res_valid_i = 1'b0; res_exc_i = '0;
      @(negedge clk);
      chk("R11", "cause kept while exceptional", 64'(exc_cause_o), 64'(4'b0010));
      chk("R10", "no iteration while exceptional", 64'(iter_valid_o), 64'(0));
      do_clear();

      // R11: statuses while idle
      @(negedge clk);
      res_valid_i = 1'b1; res_exc_i = 4'b1000;
      repeat (2) @(negedge clk);
      res_valid_i = 1'b0; res_exc_i = '0;
      @(negedge clk);
      chk("R11", "idle status ignored", 64'({exc_state_o, exc_cause_o}), 64'(0));

      // Clean eight-iteration run, stride two, wrapping inside banks (R2, R3).
      run_vec(8'h3C, 5'd7, 5'b01111, 5'b10100, 3'd7, 2'b11, -1, '0, 1, 1'b0, '0);

      // Fault on the last iteration, second slot valid (R6, R9).
      run_vec(8'h11, 5'b11001, 5'd2, 5'd30, 3'd2, 2'b00, 2, 4'b0001, 0, 1'b1, 32'hDEAD_BEEF);
      chk("R6", "last-iteration remaining", 64'(rem_iter_o), 64'(0));
      do_clear();

      // Scalar fault (R8).
      run_vec(8'h77, 5'd9, 5'd17, 5'd26, 3'd0, 2'b11, 0, 4'b0100, 1, 1'b0, '0);
      chk("R8", "scalar remaining", 64'(rem_iter_o), 64'(0));
      chk("R8", "scalar addresses unchanged", 64'(cap_word_o), 64'({8'h77, 5'd9, 5'd17, 5'd26}));
      do_clear();

      // Mid-vector fault with long status latency, stride two (R3, R6, R12).
      run_vec(8'hC3, 5'b10110, 5'd0, 5'b01011, 3'd5, 2'b11, 3, 4'b1000, 3, 1'b1, 32'h0000_00FF);
      chk("R7", "mid-vector copy", 64'(cap_word_o), 64'({8'hC3, 5'b10100, 5'b00110, 5'b01001}));
      do_clear();

      // Early fault with short latency: issue must halt early (R12).
      run_vec(8'h5A, 5'd1, 5'd2, 5'd3, 3'd7, 2'b00, 1, 4'b0010, 1, 1'b0, '0);
      chk("R6", "remaining after second of eight", 64'(rem_iter_o), 64'(5));
      do_clear();

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule